// File: doc/BRIEF.md
# Per-Core Idle State Controller

This block follows the idle level of a single processor core and drives the core's clock enable. Software asks for an idle level through one of two request channels. One is a level-read access and the other is a wait-type instruction. Each channel carries a 3-bit target code. The shallow levels, C1 and C2, are entered at once and leave the core clock running. The deep levels, C3 and C4, first start a first-level cache flush through a request/acknowledge pair. Only after the acknowledge do they drop the clock enable. C3 and C4 behave the same inside the block and differ only in the code reported outward.

Bus snoops and cacheable accesses from the sibling core never wake the core. A wake comes from one of six sources: a monitor event, which counts only while the monitor is armed, a system-management interrupt, an init request, two local interrupt lines and a bus interrupt message. When the core leaves a deep level, the clock enable returns one cycle before the reported code goes back to C0. A wake that arrives during the flush cancels the entry, and the core returns to C0 once the flush is acknowledged. An asynchronous active-low reset returns everything to C0 without any exit sequence.

Top module: `core_idle_ctrl`

## Requirements
- R1: While rst_n is low, idle_code is 0, core_clk_en is 1, flush_req is 0 and mon_armed is 0, immediately and from any state, including the middle of a flush.
- R2: Requests are taken only in C0. The level-read channel wins over the wait channel when both are high. A target outside 1..4 is ignored. A request in the same cycle as an effective wake is ignored.
- R3: A request for target 1 or 2 makes idle_code show that target on the next cycle, with core_clk_en kept at 1. An effective wake returns idle_code to 0 on the following cycle.
- R4: A request for target 3 or 4 raises flush_req on the next cycle, while idle_code stays 0 and core_clk_en stays 1. flush_req stays high until flush_done is sampled high. The cycle after that, idle_code shows the target, core_clk_en is 0 and flush_req is 0.
- R5: In C3 or C4, core_clk_en stays 0 and idle_code stays steady until an effective wake. snoop_hit and sib_access never change any output in any state.
- R6: wake_src bit 0 is the monitor event and is effective only while mon_armed is 1. Bits 1 to 5 (system-management interrupt, init, local interrupt 0, local interrupt 1, bus interrupt message) are always effective.
- R7: An effective wake in C3 or C4 sets core_clk_en to 1 on the next cycle while idle_code still shows the deep code. On the cycle after that, idle_code is 0.
- R8: An effective wake in any cycle of the flush phase, including the acknowledge cycle, makes the cycle after the acknowledge show idle_code 0 with core_clk_en 1. core_clk_en is never dropped.
- R9: mon_clr makes mon_armed 0 on the next cycle, otherwise mon_set makes it 1. With neither input high, the flag holds, including across a deep residency.
- R10: C4 follows the same sequence and timing as C3 and reports idle_code 4 instead of 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req | input | 1 | Level-read idle request |
| lvl_tgt | input | 3 | Target code of the level-read request |
| wait_req | input | 1 | Wait-instruction idle request |
| wait_tgt | input | 3 | Target code of the wait request |
| wake_src | input | 6 | Wake sources: 0 monitor, 1 SMI, 2 init, 3 local int 0, 4 local int 1, 5 bus message |
| snoop_hit | input | 1 | Bus snoop observed (non-waking) |
| sib_access | input | 1 | Sibling-core cacheable access (non-waking) |
| mon_set | input | 1 | Arm the monitor |
| mon_clr | input | 1 | Disarm the monitor |
| flush_done | input | 1 | Flush acknowledge |
| flush_req | output | 1 | Flush request to the cache |
| core_clk_en | output | 1 | Core clock enable |
| idle_code | output | 3 | Current idle level code 0..4 |
| mon_armed | output | 1 | Monitor-armed flag |

## Verification
A wrong phase register shows up on the port one cycle later as a wrong idle_code, or as core_clk_en held low outside a deep code. A lost abort flag shows as the clock enable dropping after a flush acknowledge that should have returned the core to C0. The bench compares every port on every cycle against a requirement-level model, so a divergence is reported on the cycle it first appears. Directed sequences pin the flush hold, the exit lag, the monitor masking and a reset in the middle of a flush.

// File: rtl/cidle_pkg.sv
package cidle_pkg;
   localparam int unsigned CODE_C0 = 0;
   localparam int unsigned CODE_C1 = 1;
   localparam int unsigned CODE_C2 = 2;
   localparam int unsigned CODE_C3 = 3;
   localparam int unsigned CODE_C4 = 4;

   typedef enum logic [2:0] {
      PH_ACT     = 3'd0,
      PH_SHALLOW = 3'd1,
      PH_FLUSH   = 3'd2,
      PH_DEEP    = 3'd3,
      PH_EXIT    = 3'd4
   } phase_t;
endpackage

// File: rtl/cidle_req_sel.sv
module cidle_req_sel #(
   parameter int STATE_W   = 3,
   parameter bit LVL_FIRST = 1'b1
) (
   input  logic               lvl_req,
   input  logic [STATE_W-1:0] lvl_tgt,
   input  logic               wait_req,
   input  logic [STATE_W-1:0] wait_tgt,
   output logic               req_vld,
   output logic [STATE_W-1:0] req_tgt
);
   import cidle_pkg::*;

   logic               pick_req;
   logic [STATE_W-1:0] pick_tgt;

   generate
      if (LVL_FIRST) begin : g_lvl_first
         always_comb begin
            pick_req = lvl_req | wait_req;
            pick_tgt = lvl_req ? lvl_tgt : wait_tgt;
         end
      end else begin : g_wait_first
         always_comb begin
            pick_req = lvl_req | wait_req;
            pick_tgt = wait_req ? wait_tgt : lvl_tgt;
         end
      end
   endgenerate

   assign req_vld = pick_req &&
                    (pick_tgt >= STATE_W'(CODE_C1)) &&
                    (pick_tgt <= STATE_W'(CODE_C4));
   assign req_tgt = pick_tgt;
endmodule

// File: rtl/cidle_wake_merge.sv
module cidle_wake_merge #(
   parameter int WAKE_W    = 6,
   parameter int MON_BIT   = 0,
   parameter bit MON_GATED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WAKE_W-1:0] wake_src,
   input  logic              mon_armed,
   output logic              wake_any
);
   logic [WAKE_W-1:0] gated;

   generate
      if (MON_GATED) begin : g_gate
         always_comb begin
            gated          = wake_src;
            gated[MON_BIT] = wake_src[MON_BIT] & mon_armed;
         end

         AST_MON_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            ((wake_src == (WAKE_W'(1) << MON_BIT)) && !mon_armed) |-> !wake_any); // R6
      end else begin : g_raw
         assign gated = wake_src;
      end
   endgenerate

   assign wake_any = |gated;
endmodule

// File: rtl/cidle_mon_flag.sv
module cidle_mon_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic armed
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     armed <= 1'b0;
      else if (clr_i) armed <= 1'b0;
      else if (set_i) armed <= 1'b1;
   end

   AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(armed)); // R9
endmodule

// File: rtl/cidle_fsm.sv
module cidle_fsm #(
   parameter int STATE_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  logic [STATE_W-1:0] req_tgt,
   input  logic               wake_any,
   input  logic               flush_done,
   output logic               flush_req,
   output logic               core_clk_en,
   output logic [STATE_W-1:0] idle_code
);
   import cidle_pkg::*;

   phase_t             ph_q, ph_d;
   logic [STATE_W-1:0] tgt_q, tgt_d;
   logic               abort_q, abort_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_ACT;
         tgt_q   <= '0;
         abort_q <= 1'b0;
      end else begin
         ph_q    <= ph_d;
         tgt_q   <= tgt_d;
         abort_q <= abort_d;
      end
   end

   always_comb begin
      ph_d    = ph_q;
      tgt_d   = tgt_q;
      abort_d = abort_q;
      unique case (ph_q)
         PH_ACT: begin
            if (req_vld && !wake_any) begin
               tgt_d   = req_tgt;
               abort_d = 1'b0;
               ph_d    = (req_tgt >= STATE_W'(CODE_C3)) ? PH_FLUSH : PH_SHALLOW;
            end
         end
         PH_SHALLOW: if (wake_any) ph_d = PH_ACT;
         PH_FLUSH: begin
            abort_d = abort_q | wake_any;
            if (flush_done) ph_d = (abort_q | wake_any) ? PH_ACT : PH_DEEP;
         end
         PH_DEEP:  if (wake_any) ph_d = PH_EXIT;
         PH_EXIT:  ph_d = PH_ACT;
         default:  ph_d = PH_ACT;
      endcase
   end

   assign flush_req   = (ph_q == PH_FLUSH);
   assign core_clk_en = (ph_q != PH_DEEP);
   assign idle_code   = (ph_q == PH_ACT || ph_q == PH_FLUSH) ? '0 : tgt_q;

   AST_FLUSH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !flush_done) |=> flush_req); // R4
   AST_SLEEP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_clk_en) |-> $past(flush_req && flush_done)); // R4
   AST_DEEP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      !core_clk_en |-> (idle_code == STATE_W'(CODE_C3) || idle_code == STATE_W'(CODE_C4))); // R10
   AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_DEEP && !wake_any) |=> (ph_q == PH_DEEP && $stable(idle_code))); // R5
   AST_EXIT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_clk_en) |=> (idle_code == '0)); // R7
   AST_ABORT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_FLUSH && flush_done && (abort_q || wake_any)) |=> (core_clk_en && idle_code == '0)); // R8
endmodule

// File: rtl/core_idle_ctrl.sv
module core_idle_ctrl #(
   parameter int STATE_W   = 3,
   parameter int WAKE_W    = 6,
   parameter int MON_BIT   = 0,
   parameter bit MON_GATED = 1'b1,
   parameter bit LVL_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lvl_req,
   input  logic [STATE_W-1:0] lvl_tgt,
   input  logic               wait_req,
   input  logic [STATE_W-1:0] wait_tgt,
   input  logic [WAKE_W-1:0]  wake_src,
   input  logic               snoop_hit,
   input  logic               sib_access,
   input  logic               mon_set,
   input  logic               mon_clr,
   input  logic               flush_done,
   output logic               flush_req,
   output logic               core_clk_en,
   output logic [STATE_W-1:0] idle_code,
   output logic               mon_armed
);
   generate
      if (STATE_W < 3) begin : g_bad_state_w
         $error("core_idle_ctrl: STATE_W must hold codes up to 4");
      end
      if (WAKE_W < 1) begin : g_bad_wake_w
         $error("core_idle_ctrl: WAKE_W must be positive");
      end
      if (MON_BIT >= WAKE_W || MON_BIT < 0) begin : g_bad_mon_bit
         $error("core_idle_ctrl: MON_BIT outside wake vector");
      end
   endgenerate

   logic               req_vld;
   logic [STATE_W-1:0] req_tgt;
   logic               wake_any;
   logic               non_waking;

   // Snoops and sibling accesses are observed but deliberately feed nothing.
   assign non_waking = snoop_hit | sib_access;

   cidle_req_sel #(.STATE_W(STATE_W), .LVL_FIRST(LVL_FIRST)) u_sel (
      .lvl_req (lvl_req),
      .lvl_tgt (lvl_tgt),
      .wait_req(wait_req),
      .wait_tgt(wait_tgt),
      .req_vld (req_vld),
      .req_tgt (req_tgt)
   );

   cidle_mon_flag u_mon (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(mon_set),
      .clr_i(mon_clr),
      .armed(mon_armed)
   );

   cidle_wake_merge #(.WAKE_W(WAKE_W), .MON_BIT(MON_BIT), .MON_GATED(MON_GATED)) u_wake (
      .clk      (clk),
      .rst_n    (rst_n),
      .wake_src (wake_src),
      .mon_armed(mon_armed),
      .wake_any (wake_any)
   );

   cidle_fsm #(.STATE_W(STATE_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_vld    (req_vld),
      .req_tgt    (req_tgt),
      .wake_any   (wake_any),
      .flush_done (flush_done),
      .flush_req  (flush_req),
      .core_clk_en(core_clk_en),
      .idle_code  (idle_code)
   );

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (idle_code == '0 && core_clk_en && !flush_req)); // R1
   AST_NON_WAKING_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (non_waking && !core_clk_en && wake_src == '0) |=> !core_clk_en); // R5
endmodule

// File: tb/sim_core_idle_ctrl.sv
`timescale 1ns/100ps
module sim_core_idle_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lvl_req = 0, wait_req = 0;
   logic [2:0] lvl_tgt = 0, wait_tgt = 0;
   logic [5:0] wake_src = 0;
   logic       snoop_hit = 0, sib_access = 0, mon_set = 0, mon_clr = 0, flush_done = 0;
   logic       flush_req, core_clk_en, mon_armed;
   logic [2:0] idle_code;

   int n_run = 0, n_fail = 0;

   // model phases: 0 active, 1 shallow, 2 flush, 3 deep, 4 exit
   int   m_ph = 0;
   int   m_tgt = 0;
   bit   m_ab = 0;
   bit   m_arm = 0;

   always #2.5 clk = ~clk;

   core_idle_ctrl u0 (
      .clk(clk), .rst_n(rst_n),
      .lvl_req(lvl_req), .lvl_tgt(lvl_tgt), .wait_req(wait_req), .wait_tgt(wait_tgt),
      .wake_src(wake_src), .snoop_hit(snoop_hit), .sib_access(sib_access),
      .mon_set(mon_set), .mon_clr(mon_clr), .flush_done(flush_done),
      .flush_req(flush_req), .core_clk_en(core_clk_en), .idle_code(idle_code),
      .mon_armed(mon_armed)
   );

   function automatic int exp_code();
      return (m_ph == 0 || m_ph == 2) ? 0 : m_tgt;
   endfunction
   function automatic bit exp_clk();
      return (m_ph != 3);
   endfunction
   function automatic bit exp_flush();
      return (m_ph == 2);
   endfunction
   function automatic string ph_tag();
      case (m_ph)
         0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5"; default: return "R7";
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // R6: monitor event effective only while armed
   task automatic model_step();
      bit wk;
      int sel;
      wk = (|wake_src[5:1]) || (wake_src[0] && m_arm);
      sel = lvl_req ? int'(lvl_tgt) : int'(wait_tgt);
      case (m_ph)
         0: if (!wk && (lvl_req || wait_req) && sel >= 1 && sel <= 4) begin
               m_tgt = sel; m_ab = 0; m_ph = (sel >= 3) ? 2 : 1;
            end
         1: if (wk) m_ph = 0;
         2: begin
               if (flush_done) m_ph = (m_ab || wk) ? 0 : 3;
               m_ab = m_ab | wk;
            end
         3: if (wk) m_ph = 4;
         default: m_ph = 0;
      endcase
      if (mon_clr) m_arm = 0; else if (mon_set) m_arm = 1;
   endtask

   task automatic cmp_all(input string tag);
      chk(tag, "idle_code", int'(idle_code), exp_code());
      chk(tag, "core_clk_en", int'(core_clk_en), int'(exp_clk()));
      chk(tag, "flush_req", int'(flush_req), int'(exp_flush()));
      chk("R9", "mon_armed", int'(mon_armed), int'(m_arm));
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
      model_step();
      cmp_all(ph_tag());
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      lvl_req = 0; wait_req = 0; lvl_tgt = 0; wait_tgt = 0; wake_src = 0;
      snoop_hit = 0; sib_access = 0; mon_set = 0; mon_clr = 0; flush_done = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      #0.5;
      chk("R1", "idle_code", int'(idle_code), 0);
      chk("R1", "core_clk_en", int'(core_clk_en), 1);
      chk("R1", "flush_req", int'(flush_req), 0);
      chk("R1", "mon_armed", int'(mon_armed), 0);
      m_ph = 0; m_tgt = 0; m_ab = 0; m_arm = 0;
      idle_inputs();
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #1000000;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd4711);
      idle_inputs();
      do_reset();

      // R3: shallow C1 through the wait channel, snoop ignored, local interrupt wakes
      wait_req = 1; wait_tgt = 1; cyc();
      chk("R3", "idle_code C1", int'(idle_code), 1);
      chk("R3", "clk_en in C1", int'(core_clk_en), 1);
      wait_req = 0; snoop_hit = 1; cyc(); cyc();
      chk("R5", "snoop in C1", int'(idle_code), 1);
      snoop_hit = 0; wake_src = 6'b001000; cyc();
      chk("R3", "wake from C1", int'(idle_code), 0);
      wake_src = 0; cyc();

      // R4: C3 via level read, flush held without acknowledge
      lvl_req = 1; lvl_tgt = 3; cyc();
      chk("R4", "flush_req raised", int'(flush_req), 1);
      chk("R4", "code during flush", int'(idle_code), 0);
      lvl_req = 0; cyc(); cyc(); cyc();
      chk("R4", "flush_req held", int'(flush_req), 1);
      flush_done = 1; cyc();
      chk("R4", "code after ack", int'(idle_code), 3);
      chk("R4", "clk_en after ack", int'(core_clk_en), 0);
      flush_done = 0; snoop_hit = 1; sib_access = 1; cyc(); cyc(); cyc();
      chk("R5", "deep holds under snoop", int'(core_clk_en), 0);
      snoop_hit = 0; sib_access = 0; wake_src = 6'b000001; cyc();
      chk("R6", "unarmed monitor masked", int'(core_clk_en), 0);
      wake_src = 6'b000010; cyc();
      chk("R7", "clk_en back first", int'(core_clk_en), 1);
      chk("R7", "code lags", int'(idle_code), 3);
      wake_src = 0; cyc();
      chk("R7", "code returns to C0", int'(idle_code), 0);

      // R10 + R9: C4 with armed monitor, woken by monitor event
      mon_set = 1; cyc(); mon_set = 0;
      wait_req = 1; wait_tgt = 4; cyc(); wait_req = 0;
      flush_done = 1; cyc(); flush_done = 0;
      chk("R10", "C4 code", int'(idle_code), 4);
      cyc(); cyc();
      wake_src = 6'b000001; cyc(); wake_src = 0;
      chk("R6", "armed monitor wakes", int'(core_clk_en), 1);
      cyc();
      chk("R9", "armed kept across C4", int'(mon_armed), 1);
      mon_clr = 1; mon_set = 1; cyc(); mon_clr = 0; mon_set = 0;
      chk("R9", "clear wins", int'(mon_armed), 0);

      // R8: wake during flush aborts entry
      lvl_req = 1; lvl_tgt = 3; cyc(); lvl_req = 0;
      wake_src = 6'b000100; cyc(); wake_src = 0;
      cyc();
      flush_done = 1; cyc(); flush_done = 0;
      chk("R8", "abort code", int'(idle_code), 0);
      chk("R8", "abort clk_en", int'(core_clk_en), 1);
      lvl_req = 1; lvl_tgt = 4; cyc(); lvl_req = 0;
      flush_done = 1; wake_src = 6'b100000; cyc(); flush_done = 0; wake_src = 0;
      chk("R8", "wake on ack cycle", int'(core_clk_en), 1);

      // R2: priority, invalid targets, request with wake, request outside C0
      lvl_req = 1; lvl_tgt = 2; wait_req = 1; wait_tgt = 4; cyc();
      chk("R2", "level channel wins", int'(idle_code), 2);
      lvl_tgt = 3; cyc();
      chk("R2", "request in C1 ignored", int'(flush_req), 0);
      lvl_req = 0; wait_req = 0; wake_src = 6'b010000; cyc(); wake_src = 0;
      lvl_req = 1; lvl_tgt = 5; cyc();
      chk("R2", "target 5 ignored", int'(idle_code), 0);
      lvl_tgt = 0; cyc();
      lvl_tgt = 1; wake_src = 6'b000010; cyc();
      chk("R2", "request with wake ignored", int'(idle_code), 0);
      lvl_req = 0; wake_src = 0;

      // R1: reset in the middle of a flush
      wait_req = 1; wait_tgt = 3; cyc(); wait_req = 0;
      chk("R4", "flush before reset", int'(flush_req), 1);
      do_reset();
      cyc();

      // constrained random section
      for (int i = 0; i < 4000; i++) begin
         lvl_req    = ($urandom % 6) == 0;
         wait_req   = ($urandom % 6) == 0;
         lvl_tgt    = 3'($urandom % 8);
         wait_tgt   = 3'($urandom % 8);
         wake_src   = (($urandom % 9) == 0) ? 6'(6'b1 << ($urandom % 6)) : 6'b0;
         snoop_hit  = ($urandom % 3) == 0;
         sib_access = ($urandom % 3) == 0;
         mon_set    = ($urandom % 15) == 0;
         mon_clr    = ($urandom % 25) == 0;
         flush_done = flush_req && (($urandom % 4) == 0);
         cyc();
      end
      idle_inputs();
      cyc();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule